// File: doc/BRIEF.md
# Statistics Counter Bank with Freeze

The block keeps a set of saturating event counters. The counters are split into a receive group and a transmit group. Each counter has its own event strobe, sampled once per clock. Software can set a freeze bit so that every counter holds still while it reads a consistent snapshot. Events that arrive during the freeze are not dropped. Each such cycle is stored as one bitmask entry in an internal event queue. After the freeze ends, the queue is replayed into the counters at one entry per cycle.

Two self-clearing strobes zero the receive group or the transmit group. A clear also removes that group's bits from every queued entry, so a cleared counter reads zero even after the queue has drained. When a freeze fills the queue, the freeze releases itself on the same edge, so the queue never overflows and no event is lost.

Top module: `stat_counter_bank`

## Requirements
- R1: While `freeze` reads 1, no counter value changes, except where a clear strobe of the same cycle applies (R5, R6).
- R2: In a frozen cycle, a nonzero event vector (after clear masking) becomes one queue entry. Bit i of the entry stands for counter i.
- R3: While `freeze` reads 0 and the queue is not empty, one entry is removed per cycle. Counter i then gains the entry's bit i plus its live strobe, so it can gain 2 in one cycle. Once drained, the total of every counter equals its number of events.
- R4: On the edge at which the queue becomes full, `freeze` changes to 0. This takes priority over a write of 1 in that cycle, so no event is ever rejected.
- R5: A `clr_rx` strobe sets all receive counters (lanes 0 to N_RX-1) to 0 on the next edge. It also discards that cycle's receive strobes and the receive bits of every queued entry. It applies even while frozen.
- R6: A `clr_tx` strobe does the same for the transmit counters (lanes N_RX to N_RX+N_TX-1).
- R7: After reset, `freeze` is 0 and every counter is 0. A cycle with `freeze_wr` at 1 loads `freeze_wdata` into `freeze`, which is visible after the edge.
- R8: A counter at its all-ones value stays there when events arrive. It does not wrap.
- R9: When not frozen and the queue is empty, each live strobe adds exactly 1 to its counter on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_evt | input | N_RX | Receive event strobes, one per receive counter |
| tx_evt | input | N_TX | Transmit event strobes, one per transmit counter |
| freeze_wr | input | 1 | Write strobe for the freeze bit |
| freeze_wdata | input | 1 | Value written to the freeze bit |
| clr_rx | input | 1 | Clear strobe for the receive group |
| clr_tx | input | 1 | Clear strobe for the transmit group |
| freeze | output | 1 | Current freeze bit |
| cnt_flat | output | (N_RX+N_TX)*CW | Counter values. Lane i is bits [i*CW +: CW]. Receive lanes come first. |

## Verification
The bench builds the block with three receive counters, two transmit counters, 4-bit counters and a 4-entry queue. With 4-bit counters, saturation is reached within a few dozen events. With a 4-entry queue, a freeze fills the queue and releases itself within four event cycles, so both corner cases recur often under random stimulus. These sizes also make drains that overlap live events and clears that land in the middle of a drain common. Each such case is compared against a cycle model kept in the bench.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  // Saturating add: returns min(v + inc, maxv).
  function automatic int unsigned sat_sum(int unsigned v, int unsigned inc,
                                          int unsigned maxv);
    int unsigned s;
    s = v + inc;
    return (s > maxv) ? maxv : s;
  endfunction
endpackage

// File: rtl/stat_evt_fifo.sv
module stat_evt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    push_data,
  input  logic            pop,
  input  logic [W-1:0]    clr_mask,
  output logic [W-1:0]    rd_data,
  output logic [CNTW-1:0] count,
  output logic            full_next
);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CNTW-1:0] count_next;

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    count_next = count;
    if (push) count_next = count_next + 1'b1;
    if (pop)  count_next = count_next - 1'b1;
  end

  assign full_next = (count_next == CNTW'(DEPTH));
  assign rd_data   = mem[rptr] & ~clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && wptr == AW'(i)) mem[i] <= push_data & ~clr_mask;
        else                        mem[i] <= mem[i] & ~clr_mask;
      end
      if (push) wptr <= wrap_inc(wptr);
      if (pop)  rptr <= wrap_inc(rptr);
      count <= count_next;
    end
  end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    inc,
  output logic [CW-1:0] value
);
  import stat_bank_pkg::*;
  localparam int unsigned MAXV = (1 << CW) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (clr)      value <= '0;
    else if (inc != 0) value <= CW'(sat_sum(int'(value), int'(inc), MAXV));
  end
endmodule

// File: rtl/stat_freeze_ctrl.sv
module stat_freeze_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_wr,
  input  logic freeze_wdata,
  input  logic queue_fills,
  output logic freeze_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          freeze_q <= 1'b0;
    else if (queue_fills) freeze_q <= 1'b0;
    else if (freeze_wr)   freeze_q <= freeze_wdata;
  end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
  parameter int N_RX  = 4,
  parameter int N_TX  = 4,
  parameter int CW    = 16,
  parameter int DEPTH = 8,
  localparam int NC   = N_RX + N_TX,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_RX-1:0]  rx_evt,
  input  logic [N_TX-1:0]  tx_evt,
  input  logic             freeze_wr,
  input  logic             freeze_wdata,
  input  logic             clr_rx,
  input  logic             clr_tx,
  output logic             freeze,
  output logic [NC*CW-1:0] cnt_flat
);
  // Named internal events, also observed by the checker.
  logic [NC-1:0]   ev_vec, clr_mask, ev_kept, drain_bits, fifo_rd;
  logic            push, pop, queue_fills;
  logic [CNTW-1:0] fifo_count;

  assign ev_vec   = {tx_evt, rx_evt};
  assign clr_mask = {{N_TX{clr_tx}}, {N_RX{clr_rx}}};
  assign ev_kept  = ev_vec & ~clr_mask;
  assign push     = freeze && (ev_kept != '0);
  assign pop      = !freeze && (fifo_count != '0);
  assign drain_bits = pop ? fifo_rd : '0;

  stat_evt_fifo #(.W(NC), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(ev_kept), .pop(pop),
    .clr_mask(clr_mask), .rd_data(fifo_rd), .count(fifo_count),
    .full_next(queue_fills)
  );

  stat_freeze_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .freeze_wr(freeze_wr),
    .freeze_wdata(freeze_wdata), .queue_fills(queue_fills), .freeze_q(freeze)
  );

  for (genvar i = 0; i < NC; i++) begin : g_cnt
    logic [1:0] inc;
    assign inc = {1'b0, drain_bits[i]} + {1'b0, ev_vec[i] & !freeze};
    stat_counter #(.CW(CW)) cnt_i (
      .clk(clk), .rst_n(rst_n), .clr(clr_mask[i]), .inc(inc),
      .value(cnt_flat[i*CW +: CW])
    );
  end
endmodule

// File: rtl/stat_counter_bank_chk.sv
module stat_counter_bank_chk #(
  parameter int N_RX  = 4,
  parameter int N_TX  = 4,
  parameter int CW    = 16,
  parameter int DEPTH = 8,
  localparam int NC   = N_RX + N_TX,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_rx,
  input logic             clr_tx,
  input logic             freeze,
  input logic [NC*CW-1:0] cnt_flat,
  input logic             push,
  input logic             pop,
  input logic [CNTW-1:0]  fifo_count
);
  // R1
  a_r1_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clr_rx && !clr_tx) |=> (cnt_flat == $past(cnt_flat)));
  // R2, R3: queue is filled only when frozen and drained only when released
  a_r3_no_pop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && push));
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (fifo_count == $past(fifo_count) + 1'b1));
  // R4
  a_r4_full_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CNTW'(DEPTH)) |-> !freeze);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNTW'(DEPTH));
  // R5
  a_r5_clr_rx: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rx |=> (cnt_flat[N_RX*CW-1:0] == '0));
  // R6
  a_r6_clr_tx: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tx |=> (cnt_flat[NC*CW-1:N_RX*CW] == '0));
  // R8
  for (genvar i = 0; i < NC; i++) begin : g_sat
    localparam bit IS_RX = (i < N_RX);
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_flat[i*CW +: CW] == '1) && !(IS_RX ? clr_rx : clr_tx))
        |=> (cnt_flat[i*CW +: CW] == '1));
  end
endmodule

bind stat_counter_bank stat_counter_bank_chk #(
  .N_RX(N_RX), .N_TX(N_TX), .CW(CW), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_rx(clr_rx), .clr_tx(clr_tx),
  .freeze(freeze), .cnt_flat(cnt_flat), .push(push), .pop(pop),
  .fifo_count(fifo_count)
);

// File: tb/stat_counter_bank_tb.sv
module stat_counter_bank_tb_top;
  localparam int N_RX = 3, N_TX = 2, CW = 4, DEPTH = 4;
  localparam int NC = N_RX + N_TX;
  localparam int MAXV = (1 << CW) - 1;
  localparam int RXM = (1 << N_RX) - 1;
  localparam int TXM = ((1 << NC) - 1) & ~RXM;

  logic clk = 0, rst_n = 0;
  logic [N_RX-1:0] rx_evt = '0;
  logic [N_TX-1:0] tx_evt = '0;
  logic freeze_wr = 0, freeze_wdata = 0, clr_rx = 0, clr_tx = 0;
  logic freeze;
  logic [NC*CW-1:0] cnt_flat;

  always #5 clk = ~clk;

  stat_counter_bank #(.N_RX(N_RX), .N_TX(N_TX), .CW(CW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .freeze_wr(freeze_wr), .freeze_wdata(freeze_wdata), .clr_rx(clr_rx),
    .clr_tx(clr_tx), .freeze(freeze), .cnt_flat(cnt_flat)
  );

  int n_chk = 0, n_fail = 0;
  int m_cnt [NC];
  int m_q [DEPTH+1];
  int m_qn = 0;
  bit m_frz = 0;

  function automatic int lane(int i);
    return int'(cnt_flat[i*CW +: CW]);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NC; i++) check(tag, lane(i), m_cnt[i]);
    check(tag, int'(freeze), int'(m_frz));
  endtask

  // Reference model of one clock cycle, following the requirements.
  function automatic void model_step(int ev, bit fwr, bit fwd, bit crx, bit ctx);
    int cm, pe, inc, kept;
    bit popd, nf;
    cm = (crx ? RXM : 0) | (ctx ? TXM : 0);
    for (int k = 0; k < m_qn; k++) m_q[k] &= ~cm;
    popd = !m_frz && m_qn > 0;
    pe = popd ? m_q[0] : 0;
    for (int i = 0; i < NC; i++) begin
      if (cm[i]) m_cnt[i] = 0;
      else begin
        inc = pe[i] + ((!m_frz && ev[i]) ? 1 : 0);
        m_cnt[i] = (m_cnt[i] + inc > MAXV) ? MAXV : m_cnt[i] + inc;
      end
    end
    kept = ev & ~cm;
    if (m_frz && kept != 0) begin m_q[m_qn] = kept; m_qn++; end
    if (popd) begin
      for (int k = 0; k < m_qn - 1; k++) m_q[k] = m_q[k+1];
      m_qn--;
    end
    nf = fwr ? fwd : m_frz;
    if (m_qn == DEPTH) nf = 0;
    m_frz = nf;
  endfunction

  task automatic cyc(int ev, bit fwr, bit fwd, bit crx, bit ctx, string tag);
    rx_evt = ev[N_RX-1:0];
    tx_evt = ev[NC-1:N_RX];
    freeze_wr = fwr; freeze_wdata = fwd; clr_rx = crx; clr_tx = ctx;
    model_step(ev, fwr, fwd, crx, ctx);
    @(posedge clk); #1;
    check_all(tag);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    for (int i = 0; i < NC; i++) m_cnt[i] = 0;
    seed = $urandom(32'd4711);
    #23 rst_n = 1;
    @(negedge clk);
    // R7 reset state
    for (int i = 0; i < NC; i++) check("R7 reset count", lane(i), 0);
    check("R7 reset freeze", int'(freeze), 0);
    // R9 plain counting
    cyc(5'b10101, 0, 0, 0, 0, "R9");
    check("R9 lane0", lane(0), 1);
    cyc(5'b11111, 0, 0, 0, 0, "R9");
    check("R9 lane1", lane(1), 1);
    // R7 freeze write, R1 hold, R2 queue
    cyc(0, 1, 1, 0, 0, "R7");
    check("R7 freeze set", int'(freeze), 1);
    cyc(5'b00001, 0, 0, 0, 0, "R1");
    cyc(5'b00011, 0, 0, 0, 0, "R2");
    check("R1 lane0 held", lane(0), 2);
    // release, R3 drain merged with live events
    cyc(0, 1, 0, 0, 0, "R3");
    cyc(5'b00001, 0, 0, 0, 0, "R3");
    cyc(5'b00001, 0, 0, 0, 0, "R3");
    check("R3 lane0 total", lane(0), 6);
    // R4 auto release on full
    cyc(0, 1, 1, 0, 0, "R4");
    for (int k = 0; k < DEPTH; k++) cyc(5'b10000, 0, 0, 0, 0, "R4");
    check("R4 released", int'(freeze), 0);
    for (int k = 0; k < DEPTH + 1; k++) cyc(0, 0, 0, 0, 0, "R4");
    check("R4 lane4 total", lane(4), 2 + DEPTH);
    // R5 clear during freeze discards queued rx
    cyc(0, 1, 1, 0, 0, "R5");
    cyc(5'b11111, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, "R5");
    check("R5 rx zero", lane(0), 0);
    cyc(0, 1, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, "R5");
    check("R5 rx stays zero", lane(1), 0);
    // R6 clear tx
    cyc(5'b11000, 0, 0, 0, 1, "R6");
    check("R6 tx zero", lane(3), 0);
    // R8 saturation
    for (int k = 0; k < MAXV + 3; k++) cyc(5'b00100, 0, 0, 0, 0, "R8");
    check("R8 saturated", lane(2), MAXV);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int ev, r;
      bit fwr, fwd;
      ev = int'($urandom) & ((1 << NC) - 1);
      r = int'($urandom % 100);
      fwr = (r < 12);
      fwd = (r < 8);
      cyc(ev, fwr, fwd, ($urandom % 60) == 0, ($urandom % 60) == 0, "R3 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule